// File: doc/BRIEF.md
# Display RAM Byte Packer for a Multiplexed LCD Driver

This block sits between a byte-oriented serial bus front end and the display memory of a segment LCD driver. The memory holds 24 columns of 4-bit words. Each column feeds one segment output and each bit row feeds one backplane phase. A set bit turns the segment on. The host first loads a column pointer. It then streams display bytes, and the block scatters each byte across the memory in a pattern set by the multiplex mode.

Bits are taken from the most significant end. They fill rows 0 up to N-1 of one column, then move on to the next column. N is the number of backplane rows the mode uses. The number of columns one byte covers is eight divided by N, rounded up. The pointer steps by that column count after each byte, so a stream of bytes fills the display without further pointer loads. Each touched column is updated by read-modify-write, one column per clock. While that runs, the ready signal is held low, which stalls the sender the way a held-low bus clock would. A second read port lets a display scanner fetch any column at any time.

If a transfer is aborted, the pointer is marked invalid. From then on, bytes are taken off the handshake and thrown away until the pointer is loaded again.

Top module: `lcd_ram_packer`

## Requirements
- R1: After reset every memory word reads 0, `byte_ready` is 1 and the pointer is invalid, so a byte sent before any pointer load is consumed without changing any column and without a stall.
- R2: Mode 2'b00 (static, one row): byte bit 7 goes to row 0 of column P, bit 6 to row 0 of column P+1, and so on, down to bit 0 in row 0 of column P+7. Row r of a column is bit r of `rd_word`.
- R3: Mode 2'b01 (two rows): column P gets bits 7,6 in rows 0,1, column P+1 gets bits 5,4, column P+2 gets bits 3,2 and column P+3 gets bits 1,0.
- R4: Mode 2'b10 (three rows): columns P and P+1 get bits 7..5 and 4..2 in rows 0..2. Column P+2 gets bits 1,0 in rows 0,1, and its row 2 keeps its old value.
- R5: Mode 2'b11 (four rows): column P gets bits 7..4 in rows 0..3 and column P+1 gets bits 3..0 in rows 0..3.
- R6: After each stored byte the pointer advances by 8, 4, 3 or 2 for modes 00, 01, 10 and 11, so the next byte continues where the last one ended.
- R7: Column addresses wrap from 23 to 0 when a byte runs past the last column.
- R8: A pointer load value from 24 to 31 selects column (value - 24).
- R9: After a byte is accepted for storage, `byte_ready` stays low for exactly as many cycles as the byte covers columns (8, 4, 3 or 2). A byte held valid through the stall is accepted afterwards and stored.
- R10: A cycle with `xfer_abort` high invalidates the pointer. A byte presented in that same cycle is discarded, and later bytes are discarded until the next pointer load.
- R11: `byte_ready` is low in any cycle in which `ld_ptr` is high.
- R12: Only the bit positions a byte targets change. Every other row of a touched column, and every untouched column, keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_ptr | input | 1 | Load the column pointer from `ld_addr` |
| ld_addr | input | 5 | Pointer load value, reduced modulo 24 |
| mode | input | 2 | Multiplex mode: 00 static, 01 two rows, 10 three rows, 11 four rows |
| byte_valid | input | 1 | Display byte offered |
| byte_data | input | 8 | Display byte, consumed MSB first |
| byte_ready | output | 1 | Byte taken on a clock edge where valid and ready are both high |
| xfer_abort | input | 1 | Transfer terminated early; invalidates the pointer |
| rd_col | input | 5 | Scanner read column |
| rd_word | output | 4 | Memory word at `rd_col` (bit r = row r), 0 for columns 24 to 31 |

## Verification
The memory is first filled with a checkerboard background, so that every stored bit must either flip a known value or leave it alone. A design that wrote whole words instead of masked bits would then wipe out neighbouring rows. A design that wrote a zero into the spare row of the last column in three-row mode would turn a 7 into a 3. Writes that start at columns 22 and 23 and pointer loads of 26 and 31 expose a missing wrap or an unreduced address, which would land bits in nonexistent columns or leave column 0 untouched. Stall lengths in every mode, back-to-back bytes, and aborts both on their own and in the same cycle as a byte catch a wrong pointer step, dropped data, or writes through an invalid pointer.

// File: rtl/lcd_pack_pkg.sv
package lcd_pack_pkg;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'b00,
        MODE_MUX2   = 2'b01,
        MODE_MUX3   = 2'b10,
        MODE_MUX4   = 2'b11
    } drive_mode_e;

    // Backplane rows filled per column in a given mode.
    function automatic int mode_rows(input drive_mode_e m);
        case (m)
            MODE_STATIC: return 1;
            MODE_MUX2:   return 2;
            MODE_MUX3:   return 3;
            default:     return 4;
        endcase
    endfunction

    // Columns spanned by one byte, which is also the pointer step.
    function automatic int mode_cols(input drive_mode_e m, input int byte_w);
        int r;
        r = mode_rows(m);
        return (byte_w + r - 1) / r;
    endfunction

endpackage

// File: rtl/lcd_pack_slicer.sv
module lcd_pack_slicer
    import lcd_pack_pkg::*;
#(
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8,
    parameter int CIDX_W = 3
) (
    input  logic [BYTE_W-1:0] data_i,
    input  drive_mode_e       mode_i,
    input  logic [CIDX_W-1:0] col_idx_i,
    output logic [ROWS-1:0]   mask_o,
    output logic [ROWS-1:0]   bits_o
);

    always_comb begin
        int                nrows;
        int                idx;
        logic [CIDX_W-1:0] sel;
        nrows  = mode_rows(mode_i);
        mask_o = '0;
        bits_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            idx = int'(col_idx_i) * nrows + r;
            sel = CIDX_W'(BYTE_W - 1 - idx);
            if (r < nrows && idx < BYTE_W) begin
                mask_o[r] = 1'b1;
                bits_o[r] = data_i[sel];
            end
        end
    end

endmodule

// File: rtl/lcd_pack_ptr.sv
module lcd_pack_ptr #(
    parameter int NCOLS  = 24,
    parameter int AW     = 5,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [AW-1:0]     ld_addr_i,
    input  logic              abort_i,
    input  logic              adv_i,
    input  logic [STEP_W-1:0] step_i,
    output logic [AW-1:0]     ptr_o,
    output logic              ok_o
);

    localparam logic [AW:0] NCOLS_W = (AW+1)'(NCOLS);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          ok;
    } ptr_t;

    ptr_t        st_d, st_q;
    logic [AW:0] ld_ext;
    logic [AW:0] adv_sum;

    assign ld_ext  = {1'b0, ld_addr_i};
    assign adv_sum = {1'b0, st_q.ptr} + (AW+1)'(step_i);

    always_comb begin
        st_d = st_q;
        if (ld_i) begin
            st_d.ptr = AW'((ld_ext >= NCOLS_W) ? ld_ext - NCOLS_W : ld_ext);
            st_d.ok  = 1'b1;
        end else begin
            if (adv_i) begin
                st_d.ptr = AW'((adv_sum >= NCOLS_W) ? adv_sum - NCOLS_W : adv_sum);
            end
            if (abort_i) begin
                st_d.ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
    assign ok_o  = st_q.ok;

    assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, st_q.ptr} < NCOLS_W);

    assert_abort_invalidates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !ld_i) |=> !ok_o);

endmodule

// File: rtl/lcd_pack_ram.sv
module lcd_pack_ram #(
    parameter int NCOLS = 24,
    parameter int ROWS  = 4,
    parameter int AW    = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   wcol_i,
    input  logic [ROWS-1:0] wmask_i,
    input  logic [ROWS-1:0] wbits_i,
    input  logic [AW-1:0]   rcol_i,
    output logic [ROWS-1:0] rword_o
);

    localparam logic [AW:0] NCOLS_W = (AW+1)'(NCOLS);

    logic [ROWS-1:0] mem_d [NCOLS];
    logic [ROWS-1:0] mem_q [NCOLS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[wcol_i] = (mem_q[wcol_i] & ~wmask_i) | (wbits_i & wmask_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rword_o = ({1'b0, rcol_i} < NCOLS_W) ? mem_q[rcol_i] : '0;

    assert_write_col_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> ({1'b0, wcol_i} < NCOLS_W));

    assert_hold_without_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_i ##1 $stable(rcol_i)) |-> $stable(rword_o));

endmodule

// File: rtl/lcd_ram_packer.sv
module lcd_ram_packer
    import lcd_pack_pkg::*;
#(
    parameter int NCOLS  = 24,
    parameter int ROWS   = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_ptr,
    input  logic [$clog2(NCOLS)-1:0] ld_addr,
    input  logic [1:0]               mode,
    input  logic                     byte_valid,
    input  logic [BYTE_W-1:0]        byte_data,
    output logic                     byte_ready,
    input  logic                     xfer_abort,
    input  logic [$clog2(NCOLS)-1:0] rd_col,
    output logic [ROWS-1:0]          rd_word
);

    localparam int AW     = $clog2(NCOLS);
    localparam int CIDX_W = $clog2(BYTE_W);
    localparam int STEP_W = CIDX_W + 1;

    typedef struct packed {
        logic              busy;
        logic [AW-1:0]     col;
        logic [CIDX_W-1:0] cnt;
        logic [CIDX_W-1:0] last;
        drive_mode_e       mode;
        logic [BYTE_W-1:0] data;
    } seq_t;

    seq_t              seq_d, seq_q;
    drive_mode_e       mode_e;
    logic              store;
    logic [STEP_W-1:0] step;
    logic [AW-1:0]     ptr;
    logic              ptr_ok;
    logic [ROWS-1:0]   wmask;
    logic [ROWS-1:0]   wbits;

    assign mode_e     = drive_mode_e'(mode);
    assign byte_ready = !seq_q.busy && !ld_ptr;
    assign store      = byte_valid && byte_ready && ptr_ok && !xfer_abort;
    assign step       = STEP_W'(mode_cols(mode_e, BYTE_W));

    always_comb begin
        seq_d = seq_q;
        if (store) begin
            seq_d.busy = 1'b1;
            seq_d.col  = ptr;
            seq_d.cnt  = '0;
            seq_d.last = CIDX_W'(mode_cols(mode_e, BYTE_W) - 1);
            seq_d.mode = mode_e;
            seq_d.data = byte_data;
        end else if (seq_q.busy) begin
            seq_d.col = (seq_q.col == AW'(NCOLS - 1)) ? '0 : seq_q.col + 1'b1;
            if (seq_q.cnt == seq_q.last) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    lcd_pack_ptr #(
        .NCOLS  (NCOLS),
        .AW     (AW),
        .STEP_W (STEP_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_i      (ld_ptr),
        .ld_addr_i (ld_addr),
        .abort_i   (xfer_abort),
        .adv_i     (store),
        .step_i    (step),
        .ptr_o     (ptr),
        .ok_o      (ptr_ok)
    );

    lcd_pack_slicer #(
        .ROWS   (ROWS),
        .BYTE_W (BYTE_W),
        .CIDX_W (CIDX_W)
    ) u_slicer (
        .data_i    (seq_q.data),
        .mode_i    (seq_q.mode),
        .col_idx_i (seq_q.cnt),
        .mask_o    (wmask),
        .bits_o    (wbits)
    );

    lcd_pack_ram #(
        .NCOLS (NCOLS),
        .ROWS  (ROWS),
        .AW    (AW)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (seq_q.busy),
        .wcol_i  (seq_q.col),
        .wmask_i (wmask),
        .wbits_i (wbits),
        .rcol_i  (rd_col),
        .rword_o (rd_word)
    );

    assert_store_stalls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && ptr_ok && !xfer_abort) |=> !byte_ready);

    assert_no_write_unloaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.busy && !(byte_valid && byte_ready && ptr_ok)) |=> !seq_q.busy);

    assert_mux3_spare_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.mode == MODE_MUX3 && seq_q.cnt == CIDX_W'(2)) |-> !wmask[2]);

endmodule

// File: tb/lcd_ram_packer_bench.sv
module lcd_ram_packer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ld_ptr;
    logic [4:0] ld_addr;
    logic [1:0] mode;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_ready;
    logic       xfer_abort;
    logic [4:0] rd_col;
    logic [3:0] rd_word;

    lcd_ram_packer u_lcd_ram_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_ptr     (ld_ptr),
        .ld_addr    (ld_addr),
        .mode       (mode),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_ready (byte_ready),
        .xfer_abort (xfer_abort),
        .rd_col     (rd_col),
        .rd_word    (rd_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [3:0] req;
        logic [1:0] md;
        logic [4:0] addr;
        logic [7:0] data;
        logic [4:0] col;
        logic [3:0] exp;
    } vec_t;

    // Background before each vector: even columns 4'h5, odd columns 4'hA.
    localparam int NVEC = 22;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  2'd0, 5'd0,  8'h01, 5'd0,  4'h4},  // R2
        '{4'd2,  2'd0, 5'd0,  8'h01, 5'd7,  4'hB},  // R2
        '{4'd12, 2'd0, 5'd0,  8'h01, 5'd8,  4'h5},  // R12
        '{4'd3,  2'd1, 5'd3,  8'hC5, 5'd3,  4'hB},  // R3
        '{4'd3,  2'd1, 5'd3,  8'hC5, 5'd4,  4'h4},  // R3
        '{4'd3,  2'd1, 5'd3,  8'hC5, 5'd6,  4'h6},  // R3
        '{4'd12, 2'd1, 5'd3,  8'hC5, 5'd7,  4'hA},  // R12
        '{4'd4,  2'd2, 5'd10, 8'hFF, 5'd10, 4'h7},  // R4
        '{4'd4,  2'd2, 5'd10, 8'hFF, 5'd11, 4'hF},  // R4
        '{4'd4,  2'd2, 5'd10, 8'hFF, 5'd12, 4'h7},  // R4 spare row kept
        '{4'd12, 2'd2, 5'd10, 8'hFF, 5'd13, 4'hA},  // R12
        '{4'd5,  2'd3, 5'd22, 8'h3C, 5'd22, 4'hC},  // R5
        '{4'd5,  2'd3, 5'd22, 8'h3C, 5'd23, 4'h3},  // R5
        '{4'd7,  2'd3, 5'd23, 8'h3C, 5'd0,  4'h3},  // R7
        '{4'd7,  2'd3, 5'd23, 8'h3C, 5'd23, 4'hC},  // R7
        '{4'd7,  2'd0, 5'd20, 8'hFF, 5'd1,  4'hB},  // R7
        '{4'd7,  2'd0, 5'd20, 8'hFF, 5'd23, 4'hB},  // R7
        '{4'd12, 2'd0, 5'd20, 8'hFF, 5'd4,  4'h5},  // R12
        '{4'd8,  2'd3, 5'd26, 8'h96, 5'd2,  4'h9},  // R8
        '{4'd8,  2'd3, 5'd26, 8'h96, 5'd3,  4'h6},  // R8
        '{4'd8,  2'd3, 5'd31, 8'h96, 5'd7,  4'h9},  // R8
        '{4'd8,  2'd3, 5'd31, 8'h96, 5'd8,  4'h6}   // R8
    };

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [4:0] a);
        @(negedge clk);
        ld_ptr  = 1'b1;
        ld_addr = a;
        @(negedge clk);
        ld_ptr  = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        logic acc;
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = d;
        acc = 1'b0;
        while (!acc) begin
            #1;
            acc = byte_ready;
            @(posedge clk);
            @(negedge clk);
        end
        byte_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!byte_ready) @(negedge clk);
    endtask

    task automatic read_col(input logic [4:0] c, output logic [3:0] w);
        @(negedge clk);
        rd_col = c;
        #1;
        w = rd_word;
    endtask

    task automatic fill_bg();
        mode = 2'b11;
        do_load(5'd0);
        for (int k = 0; k < 12; k++) send(8'hA5);
        wait_idle();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [3:0] w;
        int stall;
        rst_n = 1'b0; ld_ptr = 1'b0; ld_addr = '0; mode = '0;
        byte_valid = 1'b0; byte_data = '0; xfer_abort = 1'b0; rd_col = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state and invalid pointer
        #1;
        check("R1 ready after reset", byte_ready, 1);
        read_col(5'd0, w);  check("R1 col0 zero", w, 0);
        read_col(5'd23, w); check("R1 col23 zero", w, 0);
        mode = 2'b11;
        send(8'hFF);
        #1;
        check("R1 no stall on unloaded pointer", byte_ready, 1);
        repeat (3) @(negedge clk);
        read_col(5'd0, w);  check("R1 unloaded write ignored", w, 0);

        // Vector table: R2 R3 R4 R5 R7 R8 R12
        for (int i = 0; i < NVEC; i++) begin
            fill_bg();
            mode = VECS[i].md;
            do_load(VECS[i].addr);
            send(VECS[i].data);
            wait_idle();
            read_col(VECS[i].col, w);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), w, VECS[i].exp);
        end

        // R6 and R9: back-to-back bytes continue at the advanced pointer
        fill_bg();
        mode = 2'b10;
        do_load(5'd0);
        send(8'h00);
        send(8'h00);
        wait_idle();
        read_col(5'd3, w); check("R6 mux3 second byte col3", w, 4'h8);
        read_col(5'd5, w); check("R6 mux3 second byte col5", w, 4'h8);
        read_col(5'd6, w); check("R6 mux3 col6 untouched", w, 4'h5);
        fill_bg();
        mode = 2'b00;
        do_load(5'd0);
        send(8'h00);
        send(8'h00);
        wait_idle();
        read_col(5'd8, w);  check("R6 static second byte col8", w, 4'h4);
        read_col(5'd16, w); check("R6 static col16 untouched", w, 4'h5);

        // R9: stall length per mode
        for (int m = 0; m < 4; m++) begin
            mode = m[1:0];
            do_load(5'd0);
            send(8'h5A);
            stall = 0;
            while (!byte_ready) begin
                stall++;
                @(negedge clk);
            end
            check($sformatf("R9 stall cycles mode %0d", m), 8'(stall),
                  (m == 0) ? 8 : (m == 1) ? 4 : (m == 2) ? 3 : 2);
        end

        // R10: abort invalidates pointer
        fill_bg();
        mode = 2'b11;
        do_load(5'd0);
        @(negedge clk); xfer_abort = 1'b1;
        @(negedge clk); xfer_abort = 1'b0;
        send(8'h00);
        repeat (3) @(negedge clk);
        read_col(5'd0, w); check("R10 write after abort ignored", w, 4'h5);
        do_load(5'd0);
        send(8'h00);
        wait_idle();
        read_col(5'd0, w); check("R10 write after reload stored", w, 4'h0);
        // R10: abort in the same cycle as a byte
        do_load(5'd4);
        @(negedge clk);
        xfer_abort = 1'b1; byte_valid = 1'b1; byte_data = 8'h00;
        @(negedge clk);
        xfer_abort = 1'b0; byte_valid = 1'b0;
        repeat (3) @(negedge clk);
        read_col(5'd4, w); check("R10 same-cycle byte discarded", w, 4'h5);
        send(8'h00);
        repeat (3) @(negedge clk);
        read_col(5'd4, w); check("R10 later byte discarded", w, 4'h5);

        // R11: ready low while loading the pointer
        @(negedge clk);
        ld_ptr = 1'b1; ld_addr = 5'd9;
        #1;
        check("R11 ready low during load", byte_ready, 0);
        @(negedge clk);
        ld_ptr = 1'b0;
        #1;
        check("R11 ready back after load", byte_ready, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule